// File: doc/BRIEF.md
# Quarter-Wave Symmetric Waveform Sequencer

This block produces a stream of 12-bit DAC codes from a small table that describes only the first quarter of a waveform. The table holds up to sixteen offsets. The block unfolds them into a full period of up to 64 points. It does this by adding and subtracting the offsets around a programmable base code, playing the table forward and then mirrored. The output moves one point for every rising edge of an external step input. That input is asynchronous to the system clock and is synchronized inside the block.

A host programs the block through one register-write port. It writes a mode byte, a base code and a burst of table words. Table words are appended one after another to a write pointer, and the pointer returns to entry zero whenever the mode byte is written. The block runs either one period and stops, or repeats the period without end. At the last point of every period it raises a one-cycle flag.

Top module: `quarterWaveSeq`

## Requirements
- R1: After reset, `dacCode` is 0, `periodDone` is 0, the base code is 0 and sequencing is disabled.
- R2: A write with `wrSel`=2 stores `wrData[15:4]` as the next table offset, d(1) first, up to d(16). Bits 3:0 are ignored. Such writes are ignored while the enable bit (mode bit 7) is set.
- R3: While the sequencer is disabled, or enabled but not yet stepped, `dacCode` equals the base code written with `wrSel`=1 (bits 11:0).
- R4: With bipolar (mode bit 6) and symmetry (mode bit 5) set, successive steps give base+d(1..N), then base+d(N-1..0), then base−d(1..N), then base−d(N-1..0), where d(0)=0.
- R5: With symmetry set and bipolar clear, the third and fourth quarters repeat the first two with a plus sign.
- R6: With symmetry clear, a period is the first quarter only: base+d(1..N).
- R7: The depth field, mode bits 3:0, encodes N−1. The period is 4·N steps with symmetry on and N steps with symmetry off.
- R8: Every output code is saturated to the range 0..4095.
- R9: With continuous mode (mode bit 4) clear, one period is produced. The last point is then held, further steps are ignored, and `periodDone` pulses once, for one cycle.
- R10: With continuous mode set, the period repeats, and `periodDone` pulses at the last point of every period.
- R11: Each rising edge of `stepIn` advances exactly one point, however long the input stays high.
- R12: Writing the mode byte with the enable bit clear returns the sequence to its starting point, and the output returns to the base code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| wrSel | input | 2 | Write target: 0 mode byte, 1 base code, 2 table word |
| wrData | input | 16 | Write data |
| stepIn | input | 1 | Asynchronous step input, advances on rising edge |
| dacCode | output | 12 | Saturated DAC code |
| periodDone | output | 1 | One-cycle pulse at the last point of a period |

## Verification
The assertions assume that `stepIn` stays high and low for at least two system clocks each, so that the synchronizer sees every edge. They also assume that the mode byte is not changed in the middle of a period while the sequencer is running. The stimulus holds each step level for three or more cycles. It always disables the sequencer before it changes the mode, base or table, and it re-enables only afterwards. Table bursts are written only with the enable bit clear, except in the one directed test that checks that such writes are dropped.

// File: rtl/qws_pkg.sv
package qws_pkg;
  localparam int CODE_W = 12;
  localparam int TBL_AW = 4;
  localparam int TBL_N  = 1 << TBL_AW;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 2;
  localparam int MODE_W = TBL_AW + 4;

  localparam logic [SEL_W-1:0] SEL_MODE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BASE  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_TABLE = 2'd2;

  localparam int EN_BIT   = MODE_W - 1;
  localparam int BIP_BIT  = MODE_W - 2;
  localparam int SYM_BIT  = MODE_W - 3;
  localparam int CONT_BIT = MODE_W - 4;

  typedef struct packed {
    logic              loadBase;
    logic              loadWord;
    logic [TBL_AW-1:0] wrPtr;
    logic              seqOn;
    logic              negate;
    logic              zeroOff;
    logic [TBL_AW-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/qws_ctrl.sv
module qws_ctrl
  import qws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              stepIn,
  output strobe_t           strb,
  output logic              periodDone
);
  localparam int SHIFT_W = SYNC_STAGES + 1;

  logic [MODE_W-1:0] modeReg;
  logic [TBL_AW-1:0] wrPtr;
  logic [SHIFT_W-1:0] syncQ;
  logic stepRise;
  logic active, stopped;
  logic [1:0] quarter, nQuarter, lastQ;
  logic [TBL_AW-1:0] pos, nPos, depth, back;
  logic enBit, bipBit, symBit, contBit;
  logic modeWr, wordWr, advance, endNow;

  assign enBit   = modeReg[EN_BIT];
  assign bipBit  = modeReg[BIP_BIT];
  assign symBit  = modeReg[SYM_BIT];
  assign contBit = modeReg[CONT_BIT];
  assign depth   = modeReg[TBL_AW-1:0];

  assign modeWr = wrEn && (wrSel == SEL_MODE);
  assign wordWr = wrEn && (wrSel == SEL_TABLE) && !enBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      wrPtr   <= '0;
    end else begin
      if (modeWr) modeReg <= wrData[MODE_W-1:0];
      if (modeWr) wrPtr <= '0;
      else if (wordWr) wrPtr <= wrPtr + 1'b1;
    end
  end

  // step input synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SHIFT_W-2:0], stepIn};
  end
  assign stepRise = syncQ[SHIFT_W-2] & ~syncQ[SHIFT_W-1];

  assign lastQ = symBit ? 2'd3 : 2'd0;

  always_comb begin
    nQuarter = quarter;
    nPos     = pos;
    if (!active) begin
      nQuarter = 2'd0;
      nPos     = '0;
    end else if (pos >= depth) begin
      nPos     = '0;
      nQuarter = (quarter >= lastQ) ? 2'd0 : quarter + 2'd1;
    end else begin
      nPos = pos + 1'b1;
    end
  end

  assign endNow  = (nQuarter == lastQ) && (nPos == depth);
  assign advance = stepRise && enBit && !stopped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      stopped    <= 1'b0;
      quarter    <= 2'd0;
      pos        <= '0;
      periodDone <= 1'b0;
    end else if (!enBit) begin
      active     <= 1'b0;
      stopped    <= 1'b0;
      quarter    <= 2'd0;
      pos        <= '0;
      periodDone <= 1'b0;
    end else begin
      periodDone <= 1'b0;
      if (advance) begin
        active     <= 1'b1;
        quarter    <= nQuarter;
        pos        <= nPos;
        periodDone <= endNow;
        if (endNow && !contBit) stopped <= 1'b1;
      end
    end
  end

  // mirrored quarters read the table backwards; index 0 means zero offset
  assign back = depth - pos;

  always_comb begin
    strb.loadBase = wrEn && (wrSel == SEL_BASE);
    strb.loadWord = wordWr;
    strb.wrPtr    = wrPtr;
    strb.seqOn    = enBit;
    strb.negate   = bipBit && quarter[1];
    strb.zeroOff  = !active || (quarter[0] && (back == '0));
    strb.rdIdx    = quarter[0] ? back - 1'b1 : pos;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |=> !periodDone); // R9
  AST_DONE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |-> $past(stepRise)); // R10
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && $past(stopped)) |-> ($stable(pos) && $stable(quarter))); // R9
  AST_DISABLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (!active && pos == '0 && quarter == 2'd0)); // R12
endmodule

// File: rtl/qws_data.sv
module qws_data
  import qws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [CODE_W-1:0] dacCode
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [TBL_N-1:0][CODE_W-1:0] tbl;
  logic [CODE_W-1:0] baseReg, offset, nextCode;
  logic [CODE_W:0] sumWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      tbl     <= '0;
    end else begin
      if (strb.loadBase) baseReg <= wrData[CODE_W-1:0];
      if (strb.loadWord) tbl[strb.wrPtr] <= wrData[WORD_W-1 -: CODE_W];
    end
  end

  assign offset  = strb.zeroOff ? '0 : tbl[strb.rdIdx];
  assign sumWide = {1'b0, baseReg} + {1'b0, offset};

  always_comb begin
    if (strb.negate)
      nextCode = (offset > baseReg) ? '0 : baseReg - offset;
    else
      nextCode = sumWide[CODE_W] ? CODE_MAX : sumWide[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) dacCode <= '0;
    else       dacCode <= nextCode;
  end

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.seqOn && $past(strb.seqOn)) |-> $stable(tbl)); // R2
  AST_NO_WRITE_WHEN_ON: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.seqOn && strb.loadWord)); // R2
endmodule

// File: rtl/quarterWaveSeq.sv
module quarterWaveSeq
  import qws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              stepIn,
  output logic [CODE_W-1:0] dacCode,
  output logic              periodDone
);
  strobe_t strb;

  qws_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .stepIn     (stepIn),
    .strb       (strb),
    .periodDone (periodDone)
  );

  qws_data uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .dacCode (dacCode)
  );
endmodule

// File: tb/quarterWaveSeq_test.sv
`timescale 1ns/1ps
module quarterWaveSeq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic stepIn = 1'b0;
  logic [11:0] dacCode;
  logic periodDone;

  int checks = 0;
  int failures = 0;
  int doneCnt = 0;

  always #10 clk = ~clk;

  quarterWaveSeq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .stepIn(stepIn), .dacCode(dacCode), .periodDone(periodDone)
  );

  always @(posedge clk) if (rstN && periodDone) doneCnt <= doneCnt + 1;

  // scenario table: {mode byte without enable, base code}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {8'h7F, 12'd2048},  // bipolar, symmetric, continuous, N=16
    {8'h6F, 12'd2048},  // bipolar, symmetric, single, N=16
    {8'h23, 12'd1000},  // unipolar symmetric, single, N=4
    {8'h40, 12'd100},   // no symmetry, single, N=1
    {8'h73, 12'd3900},  // saturates high, continuous, N=4
    {8'h67, 12'd300},   // saturates low, single, N=8
    {8'h55, 12'd1500}   // no symmetry, continuous, N=6
  };

  function automatic int tblVal(input int j);
    return j * 97;
  endfunction

  function automatic int expCode(input logic [7:0] m, input int b, input int k);
    int n, q, r, j, v;
    n = int'(m[3:0]) + 1;
    if (k == 0) return b;
    q = m[5] ? ((k - 1) / n) % 4 : 0;
    r = (k - 1) % n;
    j = (q % 2 == 0) ? r + 1 : n - 1 - r;
    v = (m[6] && q >= 2) ? b - tblVal(j) : b + tblVal(j);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic stepPulse(input int highCycles);
    @(negedge clk);
    stepIn = 1'b1;
    repeat (highCycles) @(negedge clk);
    stepIn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] mode;
    int base, n, per, steps, kk, doneStart;
    bit cont;
    string tag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(int'(dacCode), 0, "R1 reset dacCode");
    chk(int'(periodDone), 0, "R1 reset periodDone");

    // R2: load offsets d(1..16) = j*97 in bits 15:4, low nibble junk
    wr(2'd0, 16'h0000);
    for (int j = 1; j <= 16; j++) wr(2'd2, 16'((tblVal(j) << 4) | 5));

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][19:12] & 8'h7F;
      base = int'(VEC[i][11:0]);
      n    = int'(mode[3:0]) + 1;
      per  = mode[5] ? 4 * n : n;
      cont = mode[4];
      wr(2'd0, {8'h00, mode});
      wr(2'd1, 16'(base));
      repeat (3) @(negedge clk);
      chk(int'(dacCode), base, $sformatf("R3 scenario %0d base while disabled", i));
      doneStart = doneCnt;
      wr(2'd0, {8'h00, mode | 8'h80});
      repeat (3) @(negedge clk);
      chk(int'(dacCode), base, $sformatf("R3 scenario %0d base before first step", i));
      steps = cont ? 2 * per + 1 : per + 2;
      tag = mode[5] ? (mode[6] ? "R4" : "R5") : "R6";
      for (int k = 1; k <= steps; k++) begin
        stepPulse(3);
        kk = cont ? ((k - 1) % per) + 1 : ((k > per) ? per : k);
        chk(int'(dacCode), expCode(mode, base, kk),
            $sformatf("%s R8 R2 scenario %0d step %0d", tag, i, k));
      end
      // R7: depth field N-1 sets the period; done count per R9 / R10
      if (cont)
        chk(doneCnt - doneStart, 2, $sformatf("R10 R7 scenario %0d done pulses", i));
      else
        chk(doneCnt - doneStart, 1, $sformatf("R9 R7 scenario %0d done pulses", i));
    end

    // R2: table writes while enabled are dropped
    wr(2'd0, 16'h0063);
    wr(2'd1, 16'd2000);
    wr(2'd0, 16'h00E3);
    for (int j = 0; j < 16; j++) wr(2'd2, 16'hFFF0);
    wr(2'd0, 16'h0063);
    wr(2'd0, 16'h00E3);
    for (int k = 1; k <= 4; k++) stepPulse(3);
    chk(int'(dacCode), 2000 + tblVal(4), "R2 table unchanged by writes while enabled");

    // R11: a long high level on stepIn advances one point only
    wr(2'd0, 16'h0063);
    wr(2'd0, 16'h00E3);
    stepPulse(25);
    chk(int'(dacCode), 2000 + tblVal(1), "R11 long pulse one advance");
    stepPulse(3);
    chk(int'(dacCode), 2000 + tblVal(2), "R11 next edge advances");

    // R12: clearing enable returns to start
    wr(2'd0, 16'h0063);
    repeat (3) @(negedge clk);
    chk(int'(dacCode), 2000, "R12 disable returns to base");
    wr(2'd0, 16'h00E3);
    stepPulse(3);
    chk(int'(dacCode), 2000 + tblVal(1), "R12 restart from first point");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule